// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo audio from a three-wire serial link: a bit clock, a frame sync and one data line. It runs as a slave, so all clocks come from outside. Its own clock input is the serial bit clock, and data and frame sync are sampled on its rising edge. Each frame-sync period is 64 bit clocks long and holds a left and a right sample, one per 32-bit half-frame. Every completed half-frame produces one 32-bit write toward a downstream FIFO, together with a channel tag.

The framing convention is chosen at run time: I2S, left-justified or right-justified. The sample width is chosen separately. The receiver finds half-frame starts from frame-sync transitions and collects the sample bits that belong to the selected window. It then presents the sample MSB-aligned in the output word. A word that completes while the FIFO reports full is discarded, and a sticky overflow flag records the loss. A combination of format and width that is not supported keeps the receiver idle and raises an error flag.

Top module: `audio_serial_rx`

## Requirements
- R1: Any change of the sampled frame-sync level starts a half-frame. After it, exactly one word is written per half-frame of 32 bit clocks, two per 64-clock frame. `wr_chan` is 0 for the left sample and 1 for the right.
- R2: With `fmt`=0 (I2S), a low frame-sync level marks the left channel. The sample MSB is on the data line one bit clock after the frame-sync transition. Width codes 3 (24 bits) and 4 (32 bits) are legal.
- R3: With `fmt`=1 (left-justified), a high frame-sync level marks the left channel. The MSB is sampled on the same bit clock as the transition. Width codes 3 and 4 are legal.
- R4: With `fmt`=2 (right-justified), a high level marks the left channel and the sample LSB sits on the last (32nd) bit of the half-frame. Width codes 0=16, 1=18, 2=20, 3=24 and 4=32 bits are all legal.
- R5: The written word carries the sample in its top bits. All bits below the sample width are zero, and data bits outside the sample window have no effect.
- R6: `wr_en` is a single-cycle pulse, high on the bit clock that follows the half-frame's 32nd bit.
- R7: A word that completes while `fifo_full` is high is not written (`wr_en` stays low), and `ovf` is high from the next bit clock.
- R8: `ovf` stays set until `ovf_clr` is high on a clock edge. If a new drop happens on the same edge as a clear, `ovf` stays set.
- R9: `fmt`=3, width codes 5 to 7, or a width outside its format's legal set raise `cfg_err` one clock later, and then no word is written.
- R10: While `rst_n` is low, `wr_en`, `ovf` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, data sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync (word select) |
| sdata | input | 1 | Serial data, MSB first |
| fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 reserved |
| wsel | input | 3 | Sample width code: 0=16, 1=18, 2=20, 3=24, 4=32 |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 32 | MSB-aligned sample word |
| wr_chan | output | 1 | 0 left, 1 right |
| ovf | output | 1 | Sticky overflow flag |
| cfg_err | output | 1 | Unsupported format/width selection |

## Verification
The hardest case to reach from the ports is a drop and a clear landing on the same edge. That needs `fifo_full` and `ovf_clr` both high on exactly the clock that carries a half-frame's 32nd bit. The bench builds each stream as an indexed array of bit slots. It knows the slot where every half-frame ends, so it can raise `fifo_full` and `ovf_clr` on a chosen completion slot, or on a slot with no completion. A behavioural model tracks the expected write and flag state on every clock.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  // Sample width in bits for a width code; zero for an unused code.
  function automatic logic [5:0] width_of(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd16;
      3'd1:    return 6'd18;
      3'd2:    return 6'd20;
      3'd3:    return 6'd24;
      3'd4:    return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic cfg_legal(input fmt_e f, input logic [2:0] code);
    case (f)
      FMT_I2S, FMT_LEFT: return (code == 3'd3) || (code == 3'd4);
      FMT_RIGHT:         return (code <= 3'd4);
      default:           return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/asr_fsync_det.sv
module asr_fsync_det (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic msb_delay,
  output logic hf_start,
  output logic hf_level
);
  logic fs_d1_q, fs_d2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_d1_q <= 1'b0;
      fs_d2_q <= 1'b0;
    end else begin
      fs_d1_q <= fsync;
      fs_d2_q <= fs_d1_q;
    end
  end

  // Delayed framing looks at the transition one bit clock later.
  always_comb begin
    if (msb_delay) begin
      hf_start = fs_d1_q ^ fs_d2_q;
      hf_level = fs_d1_q;
    end else begin
      hf_start = fsync ^ fs_d1_q;
      hf_level = fsync;
    end
  end
endmodule

// File: rtl/asr_capture.sv
module asr_capture #(
  parameter int DW = 32,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hf_start,
  input  logic          hf_level,
  input  logic          left_lvl,
  input  logic          rjust,
  input  logic [CW:0]   width,
  input  logic          sdata,
  output logic          emit,
  output logic [DW-1:0] word,
  output logic          chan
);
  localparam logic [CW:0]   DW_L   = DW[CW:0];
  localparam logic [CW-1:0] LAST_P = CW'(DW - 1);
  localparam logic [CW-1:0] ONE_P  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n, pos;
  logic          locked_q, locked_n;
  logic          chan_q, chan_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          active, capt, last;
  logic [CW:0]   shamt;

  always_comb begin
    pos    = hf_start ? '0 : cnt_q;
    active = hf_start | locked_q;
    capt   = rjust ? ({1'b0, pos} >= (DW_L - width)) : ({1'b0, pos} < width);
    last   = active && (pos == LAST_P);
    sh_n   = (active && capt) ? {sh_q[DW-2:0], sdata} : sh_q;
    cnt_n  = active ? pos + ONE_P : cnt_q;
    chan_n = hf_start ? (hf_level != left_lvl) : chan_q;
    if (!run)          locked_n = 1'b0;
    else if (hf_start) locked_n = 1'b1;
    else if (last)     locked_n = 1'b0;
    else               locked_n = locked_q;
    shamt  = DW_L - width;
    emit   = last & run;
    word   = sh_n << shamt;
    chan   = chan_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      chan_q   <= 1'b0;
      sh_q     <= '0;
    end else begin
      cnt_q    <= cnt_n;
      locked_q <= locked_n;
      chan_q   <= chan_n;
      sh_q     <= sh_n;
    end
  end

  // R1: a completed half-frame leaves the receiver waiting for a new transition
  p_relock_after_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !hf_start) |=> !locked_q);
  // R1: a transition restarts bit counting at slot one
  p_start_counts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hf_start |=> (cnt_q == ONE_P));
endmodule

// File: rtl/asr_wrport.sv
module asr_wrport #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emit,
  input  logic [DW-1:0] word,
  input  logic          chan,
  input  logic          fifo_full,
  input  logic          ovf_clr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          wr_chan,
  output logic          ovf
);
  logic          wr_en_q, wr_en_n, chan_q, chan_n, ovf_q, ovf_n;
  logic [DW-1:0] data_q, data_n;
  logic          drop;

  always_comb begin
    drop    = emit & fifo_full;
    wr_en_n = emit & ~fifo_full;
    data_n  = wr_en_n ? word : data_q;
    chan_n  = wr_en_n ? chan : chan_q;
    ovf_n   = drop | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q <= 1'b0;
      data_q  <= '0;
      chan_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      wr_en_q <= wr_en_n;
      data_q  <= data_n;
      chan_q  <= chan_n;
      ovf_q   <= ovf_n;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_data = data_q;
  assign wr_chan = chan_q;
  assign ovf     = ovf_q;

  p_drop_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && fifo_full) |=> (!wr_en && ovf));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  p_wr_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int DW = WORD_W,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          sdata,
  input  logic [1:0]    fmt,
  input  logic [2:0]    wsel,
  input  logic          fifo_full,
  input  logic          ovf_clr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          wr_chan,
  output logic          ovf,
  output logic          cfg_err
);
  fmt_e        f;
  logic        legal, msb_delay, left_lvl, rjust;
  logic [CW:0] width;
  logic        hf_start, hf_level, emit, chan;
  logic [DW-1:0] word;
  logic        cfg_err_q;

  always_comb begin
    f         = fmt_e'(fmt);
    legal     = cfg_legal(f, wsel);
    width     = (CW + 1)'(width_of(wsel));
    msb_delay = (f == FMT_I2S);
    left_lvl  = (f != FMT_I2S);
    rjust     = (f == FMT_RIGHT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err_q <= 1'b0;
    else        cfg_err_q <= ~legal;
  end
  assign cfg_err = cfg_err_q;

  asr_fsync_det u_det (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .msb_delay(msb_delay),
    .hf_start(hf_start), .hf_level(hf_level)
  );

  asr_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .run(legal), .hf_start(hf_start),
    .hf_level(hf_level), .left_lvl(left_lvl), .rjust(rjust), .width(width),
    .sdata(sdata), .emit(emit), .word(word), .chan(chan)
  );

  asr_wrport #(.DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .emit(emit), .word(word), .chan(chan),
    .fifo_full(fifo_full), .ovf_clr(ovf_clr), .wr_en(wr_en),
    .wr_data(wr_data), .wr_chan(wr_chan), .ovf(ovf)
  );

  p_idle_on_cfg_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !wr_en);
endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
  localparam int N = 256;
  localparam int P = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, fsync, sdata, fifo_full, ovf_clr;
  logic [1:0] fmt;
  logic [2:0] wsel;
  logic wr_en, wr_chan, ovf, cfg_err;
  logic [31:0] wr_data;

  audio_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata), .fmt(fmt),
    .wsel(wsel), .fifo_full(fifo_full), .ovf_clr(ovf_clr), .wr_en(wr_en),
    .wr_data(wr_data), .wr_chan(wr_chan), .ovf(ovf), .cfg_err(cfg_err)
  );

  int checks = 0, failures = 0, len = 0;
  bit done = 0;
  logic a_fs[N], a_sd[N], a_full[N], a_clr[N], a_emit[N], a_chan[N];
  logic [31:0] a_word[N];
  int h_end[8];
  logic pend_v, pend_c, ovf_m, err_m;
  logic [31:0] pend_d;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal_of(input int f, input int code);
    if (f == 2) return code <= 4;
    if (f < 2)  return code == 3 || code == 4;
    return 0;
  endfunction

  task automatic do_reset(input int f, input int code);
    rst_n = 0; fmt = 2'(f); wsel = 3'(code);
    fsync = 0; sdata = 0; fifo_full = 0; ovf_clr = 0;
    repeat (3) @(negedge clk);
    chk(!wr_en && !ovf && !cfg_err, "R10", "reset outputs",
        {wr_en, ovf, cfg_err}, 0);
    rst_n = 1;
    pend_v = 0; ovf_m = 0; err_m = !legal_of(f, code);
  endtask

  // Builds a stream of nfr frames; bits outside the sample window are ones.
  task automatic build(input int f, input int w, input int nfr);
    bit i2s = (f == 0);
    logic lvl_left = i2s ? 1'b0 : 1'b1;
    len = P + 64 * nfr + 3;
    for (int t = 0; t < N; t++) begin
      a_fs[t] = ~lvl_left; a_sd[t] = 1'b1; a_full[t] = 0; a_clr[t] = 0;
      a_emit[t] = 0; a_word[t] = '0; a_chan[t] = 0;
    end
    for (int k = 0; k < 2 * nfr; k++) begin
      logic [63:0] samp, tmp;
      int s;
      samp = {32'b0, $urandom()};
      if (w < 32) samp = samp & ((64'd1 << w) - 1);
      tmp = samp << (32 - w);
      for (int i = 0; i < 32; i++) a_fs[P + 32 * k + i] = (k % 2 == 0) ? lvl_left : ~lvl_left;
      s = P + 32 * k + (i2s ? 1 : 0);
      for (int i = 0; i < 32; i++) begin
        if (f == 2) begin
          if (i >= 32 - w) a_sd[s + i] = samp[31 - i];
        end else if (i < w) a_sd[s + i] = samp[w - 1 - i];
      end
      a_emit[s + 31] = 1; a_word[s + 31] = tmp[31:0]; a_chan[s + 31] = (k % 2 == 1);
      h_end[k] = s + 31;
    end
  endtask

  task automatic play(input string req);
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      chk(wr_en == pend_v, req, "wr_en (R1/R6)", wr_en, pend_v);
      if (pend_v && wr_en) begin
        chk(wr_data == pend_d, req, "wr_data (R5)", wr_data, pend_d);
        chk(wr_chan == pend_c, req, "wr_chan (R1)", wr_chan, pend_c);
      end
      chk(ovf == ovf_m, req, "ovf (R7/R8)", ovf, ovf_m);
      chk(cfg_err == err_m, req, "cfg_err (R9)", cfg_err, err_m);
      fsync = a_fs[t]; sdata = a_sd[t]; fifo_full = a_full[t]; ovf_clr = a_clr[t];
      begin
        bit e = a_emit[t] && !err_m;
        pend_v = e && !a_full[t];
        pend_d = a_word[t];
        pend_c = a_chan[t];
        ovf_m = (e && a_full[t]) || (ovf_m && !a_clr[t]);
      end
    end
  endtask

  task automatic run_case(input int f, input int code, input int w, input int nfr,
                          input string req);
    do_reset(f, code);
    build(f, w, nfr);
    play(req);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    // R2: I2S, both legal widths
    run_case(0, 4, 32, 2, "R2");
    run_case(0, 3, 24, 2, "R2");
    // R3: left-justified
    run_case(1, 4, 32, 2, "R3");
    run_case(1, 3, 24, 2, "R3");
    // R4: right-justified, every width
    run_case(2, 0, 16, 2, "R4");
    run_case(2, 1, 18, 2, "R4");
    run_case(2, 2, 20, 2, "R4");
    run_case(2, 3, 24, 2, "R4");
    run_case(2, 4, 32, 2, "R4");
    // R7/R8: drop, sticky hold, clear, simultaneous drop and clear
    do_reset(1, 3);
    build(1, 24, 3);
    a_full[h_end[1]] = 1;
    a_clr[h_end[2] - 5] = 1;
    a_full[h_end[3]] = 1; a_clr[h_end[3]] = 1;
    a_full[h_end[4] - 3] = 1;
    a_clr[h_end[5] + 1] = 1;
    play("R7");
    // R8: clear alone on a quiet cycle (no completion)
    do_reset(2, 0);
    build(2, 16, 2);
    a_full[h_end[0]] = 1;
    a_clr[h_end[1] - 10] = 1;
    play("R8");
    // R9: unsupported selections
    run_case(0, 0, 16, 2, "R9");
    run_case(1, 2, 20, 1, "R9");
    run_case(3, 4, 32, 1, "R9");
    run_case(2, 5, 16, 1, "R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule